// File: doc/BRIEF.md
# Prescaled Timer Counter with Queued Period Update

This block is the counting core of a general-purpose timer. An 8-bit divider produces a clock enable that fires once every (divider + 1) cycles of the source clock. A 16-bit counter moves on each such enable in one of three running modes: count up and stop, count up and wrap, or count up then down in a triangle. The counter can be bounded by the full 16-bit range or by a programmable period value.

A second period register queues a new period for later. The queued value becomes the active period only when the counter returns to zero by itself, so the length of a running waveform changes without a broken cycle. Restarting the counter by a mode write never applies the queued value. A mode write also discards it, and it raises a one-cycle flush pulse so that neighbouring compare channels can drop their own queued values.

The block exposes the count, a strobe for each natural return to zero, and the divided tick. Other logic uses these for compare matching and for pipelined updates.

Top module: `pscnt_top`

## Requirements
- R1: After reset the count is 0, and zeroStrobe, tickEn and flushQueue are all 0.
- R2: While a running mode is active, tickEn is high for one cycle in every (div + 1) cycles. The first high cycle comes div cycles after the cycle that follows the mode write. A div of 0 gives a tick every cycle and 255 gives one every 256 cycles. tickEn is 0 in the disabled mode.
- R3: The count changes only on a tick or on a mode write. A write of the disabled mode (modeIn = 2'b00) stops the count and holds its value.
- R4: Writing a running mode (2'b01 up once, 2'b10 up periodic, 2'b11 up/down periodic) sets the count to 0 on the next cycle, with no zero strobe.
- R5: The count limit is the period value when period-enable is 1, and 0xFFFF when it is 0.
- R6: In up-once mode the count rises by one per tick and then holds at the limit.
- R7: In up-periodic mode the count rises by one per tick and wraps to 0 on the tick after it reaches the limit.
- R8: In up/down mode the count rises to the limit, falls by one per tick to 0, and repeats.
- R9: zeroStrobe is high for exactly the cycle in which the count has just reached 0 by counting in a periodic mode.
- R10: A queued period written to the shadow register becomes the active period when the count next reaches 0 by counting.
- R11: A mode write discards any queued period, and a restart never applies it. flushQueue is high for the one cycle after any mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWe | input | 1 | Mode write strobe |
| modeIn | input | 2 | Mode value: 00 off, 01 up once, 10 up periodic, 11 up/down |
| tgtEnWe | input | 1 | Period-enable write strobe |
| tgtEnIn | input | 1 | Period-enable value |
| tgtWe | input | 1 | Active period write strobe |
| tgtIn | input | 16 | Active period value |
| shadowWe | input | 1 | Queued period write strobe |
| shadowIn | input | 16 | Queued period value |
| divWe | input | 1 | Divider write strobe |
| divIn | input | 8 | Divider value, ratio is div + 1 |
| count | output | 16 | Current counter value |
| zeroStrobe | output | 1 | One-cycle pulse when the count returns to 0 |
| tickEn | output | 1 | Divided clock enable |
| flushQueue | output | 1 | One-cycle pulse after a mode write that clears queued updates |

## Verification
A mode write takes effect on the edge that samples it: the count reads 0 and flushQueue reads 1 in the cycle after, and tickEn first rises div cycles later. From then on, the count after N further edges equals the number of ticks, floor(N / (div + 1)), folded through the mode's wrap or turn rule. zeroStrobe and a queued period transfer appear on the same edge at which the count becomes 0. The bench drives each write for exactly one edge and samples at the falling edge after a counted number of rising edges, so each expected value comes from that edge arithmetic alone.

// File: rtl/pscnt_pkg.sv
package pscnt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_LOOP = 2'b10,
    MODE_UPDN = 2'b11
  } tmode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   tick;
    logic   restart;
    tmode_e mode;
  } ctlStrobe_t;
endpackage

// File: rtl/pscnt_ctrl.sv
module pscnt_ctrl
  import pscnt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWe,
  input  logic [1:0]       modeIn,
  input  logic             tgtEnWe,
  input  logic             tgtEnIn,
  input  logic             tgtWe,
  input  logic [CNT_W-1:0] tgtIn,
  input  logic             shadowWe,
  input  logic [CNT_W-1:0] shadowIn,
  input  logic             divWe,
  input  logic [DIV_W-1:0] divIn,
  input  logic             zeroEv,
  output ctlStrobe_t       strobe,
  output logic [CNT_W-1:0] limit,
  output logic             flushQueue
);
  tmode_e           modeQ;
  logic             tgtEnQ;
  logic [CNT_W-1:0] targetQ;
  logic [CNT_W-1:0] shadowQ;
  logic             shadowPendQ;
  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] preCntQ;
  logic             flushQ;
  logic             running;
  logic             tick;

  assign running = (modeQ != MODE_OFF);
  assign tick    = running && (preCntQ >= divQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= MODE_OFF;
      tgtEnQ      <= 1'b0;
      targetQ     <= '0;
      shadowQ     <= '0;
      shadowPendQ <= 1'b0;
      divQ        <= '0;
      preCntQ     <= '0;
      flushQ      <= 1'b0;
    end else begin
      flushQ <= modeWe;
      if (modeWe)  modeQ  <= tmode_e'(modeIn);
      if (tgtEnWe) tgtEnQ <= tgtEnIn;
      if (divWe)   divQ   <= divIn;

      // prescaler restarts with the mode and idles when off
      if (modeWe || !running || tick) preCntQ <= '0;
      else                            preCntQ <= preCntQ + 1'b1;

      // queued period: dropped by a mode write, applied on natural zero
      if (modeWe) begin
        shadowPendQ <= 1'b0;
      end else if (zeroEv && shadowPendQ) begin
        targetQ     <= shadowQ;
        shadowPendQ <= shadowWe;
      end else if (shadowWe) begin
        shadowPendQ <= 1'b1;
      end
      if (shadowWe) shadowQ <= shadowIn;
      if (tgtWe)    targetQ <= tgtIn;
    end
  end

  assign limit          = tgtEnQ ? targetQ : '1;
  assign strobe.tick    = tick;
  assign strobe.restart = modeWe && (modeIn != 2'b00);
  assign strobe.mode    = modeQ;
  assign flushQueue     = flushQ;
endmodule

// File: rtl/pscnt_datapath.sv
module pscnt_datapath
  import pscnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             zeroEv,
  output logic             zeroStrobe
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] nextCnt;
  logic             downQ;
  logic             nextDown;
  logic             zeroQ;
  logic             periodic;

  always_comb begin
    nextCnt  = cntQ;
    nextDown = downQ;
    case (strobe.mode)
      MODE_ONCE: if (cntQ < limit) nextCnt = cntQ + 1'b1;
      MODE_LOOP: nextCnt = (cntQ >= limit) ? '0 : cntQ + 1'b1;
      MODE_UPDN: begin
        if (limit == '0) begin
          nextCnt  = '0;
          nextDown = 1'b0;
        end else if (!downQ) begin
          if (cntQ >= limit) begin
            nextCnt  = cntQ - 1'b1;
            nextDown = (cntQ > 1);
          end else begin
            nextCnt = cntQ + 1'b1;
          end
        end else if (cntQ <= 1) begin
          nextCnt  = '0;
          nextDown = 1'b0;
        end else begin
          nextCnt = cntQ - 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign periodic = (strobe.mode == MODE_LOOP) || (strobe.mode == MODE_UPDN);
  assign zeroEv   = strobe.tick && !strobe.restart && periodic && (nextCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      downQ <= 1'b0;
      zeroQ <= 1'b0;
    end else begin
      zeroQ <= zeroEv;
      if (strobe.restart) begin
        cntQ  <= '0;
        downQ <= 1'b0;
      end else if (strobe.tick) begin
        cntQ  <= nextCnt;
        downQ <= nextDown;
      end
    end
  end

  assign count      = cntQ;
  assign zeroStrobe = zeroQ;
endmodule

// File: rtl/pscnt_top.sv
module pscnt_top
  import pscnt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWe,
  input  logic [1:0]       modeIn,
  input  logic             tgtEnWe,
  input  logic             tgtEnIn,
  input  logic             tgtWe,
  input  logic [CNT_W-1:0] tgtIn,
  input  logic             shadowWe,
  input  logic [CNT_W-1:0] shadowIn,
  input  logic             divWe,
  input  logic [DIV_W-1:0] divIn,
  output logic [CNT_W-1:0] count,
  output logic             zeroStrobe,
  output logic             tickEn,
  output logic             flushQueue
);
  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] limit;
  logic             zeroEv;

  pscnt_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .modeWe(modeWe), .modeIn(modeIn),
    .tgtEnWe(tgtEnWe), .tgtEnIn(tgtEnIn),
    .tgtWe(tgtWe), .tgtIn(tgtIn),
    .shadowWe(shadowWe), .shadowIn(shadowIn),
    .divWe(divWe), .divIn(divIn),
    .zeroEv(zeroEv), .strobe(strobe), .limit(limit),
    .flushQueue(flushQueue)
  );

  pscnt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .limit(limit),
    .count(count), .zeroEv(zeroEv), .zeroStrobe(zeroStrobe)
  );

  assign tickEn = strobe.tick;
endmodule

// File: rtl/pscnt_chk.sv
module pscnt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeWe,
  input logic [1:0]       modeIn,
  input logic             tickEn,
  input logic [CNT_W-1:0] count,
  input logic             zeroStrobe
);
  // R3: no tick and no mode write leaves the count untouched
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !modeWe) |=> $stable(count));

  // R3: a tick moves the count by at most one step, or wraps to zero
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !modeWe) |=> (count == $past(count)) || (count == '0) ||
      (count == CNT_W'($past(count) + 1'b1)) || (count == CNT_W'($past(count) - 1'b1)));

  // R4: restart lands on zero without a strobe
  a_r4_restart: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && (modeIn != 2'b00)) |=> (count == '0) && !zeroStrobe);

  // R9: the strobe only accompanies a zero count
  a_r9_zero: assert property (@(posedge clk) disable iff (!rstN)
    zeroStrobe |-> (count == '0));
endmodule

bind pscnt_top pscnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeIn(modeIn),
  .tickEn(tickEn), .count(count), .zeroStrobe(zeroStrobe)
);

// File: tb/pscnt_top_tb.sv
module pscnt_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWe = 1'b0;
  logic [1:0]  modeIn = 2'b00;
  logic        tgtEnWe = 1'b0;
  logic        tgtEnIn = 1'b0;
  logic        tgtWe = 1'b0;
  logic [15:0] tgtIn = '0;
  logic        shadowWe = 1'b0;
  logic [15:0] shadowIn = '0;
  logic        divWe = 1'b0;
  logic [7:0]  divIn = '0;
  logic [15:0] count;
  logic        zeroStrobe;
  logic        tickEn;
  logic        flushQueue;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pscnt_top u_dut (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeIn(modeIn),
    .tgtEnWe(tgtEnWe), .tgtEnIn(tgtEnIn), .tgtWe(tgtWe), .tgtIn(tgtIn),
    .shadowWe(shadowWe), .shadowIn(shadowIn), .divWe(divWe), .divIn(divIn),
    .count(count), .zeroStrobe(zeroStrobe), .tickEn(tickEn), .flushQueue(flushQueue)
  );

  typedef struct packed {
    logic [7:0]  div;
    logic        en;
    logic [15:0] tgt;
    logic [1:0]  mode;
    logic [15:0] edges;
    logic [15:0] expCnt;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   1'b0, 16'd4, 2'b10, 16'd10,  16'd10}, // R5 R7 enable off ignores period
    '{8'd3,   1'b0, 16'd0, 2'b10, 16'd10,  16'd2},  // R2 divide by 4
    '{8'd0,   1'b1, 16'd5, 2'b10, 16'd8,   16'd2},  // R7 wrap at 5
    '{8'd0,   1'b1, 16'd5, 2'b01, 16'd20,  16'd5},  // R6 hold at 5
    '{8'd0,   1'b1, 16'd4, 2'b11, 16'd6,   16'd2},  // R8 turn at 4
    '{8'd1,   1'b1, 16'd3, 2'b11, 16'd12,  16'd0},  // R8 back at 0
    '{8'd255, 1'b0, 16'd0, 2'b10, 16'd512, 16'd2}   // R2 divide by 256
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sel: 0 mode, 1 period-enable, 2 period, 3 shadow, 4 divider
  task automatic wr(input int sel, input logic [15:0] v);
    case (sel)
      0: begin modeWe = 1'b1;   modeIn = v[1:0];  end
      1: begin tgtEnWe = 1'b1;  tgtEnIn = v[0];   end
      2: begin tgtWe = 1'b1;    tgtIn = v;        end
      3: begin shadowWe = 1'b1; shadowIn = v;     end
      default: begin divWe = 1'b1; divIn = v[7:0]; end
    endcase
    @(negedge clk);
    modeWe = 1'b0; tgtEnWe = 1'b0; tgtWe = 1'b0; shadowWe = 1'b0; divWe = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    edges(2);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 zeroStrobe", zeroStrobe, 0);
    check("R1 tickEn", tickEn, 0);
    check("R1 flushQueue", flushQueue, 0);
    rstN = 1'b1;
    edges(2);

    for (int i = 0; i < NV; i++) begin
      wr(4, 16'(VECS[i].div));
      wr(1, 16'(VECS[i].en));
      wr(2, VECS[i].tgt);
      wr(0, 16'(VECS[i].mode));
      edges(int'(VECS[i].edges));
      check($sformatf("vector %0d (R2 R5 R6 R7 R8)", i), count, VECS[i].expCnt);
    end

    // R2 tick spacing with div 2
    wr(4, 16'd2);
    wr(0, 16'd2);
    check("R2 tick c0", tickEn, 0);
    edges(1); check("R2 tick c1", tickEn, 0);
    edges(1); check("R2 tick c2", tickEn, 1);
    edges(1); check("R2 tick c3", tickEn, 0);

    // R4 restart from a running count
    wr(4, 16'd0);
    wr(1, 16'd0);
    wr(0, 16'd2);
    edges(5);
    check("R4 running", count, 5);
    wr(0, 16'd3);
    check("R4 restart count", count, 0);
    check("R4 restart strobe", zeroStrobe, 0);
    // R11 flush pulse
    check("R11 flush high", flushQueue, 1);
    edges(1);
    check("R11 flush low", flushQueue, 0);

    // R3 disabled mode holds
    wr(0, 16'd2);
    wr(0, 16'd0);
    edges(5);
    check("R3 held count", count, 1);
    check("R3 no tick", tickEn, 0);

    // R5 period ignored without enable
    wr(2, 16'd3);
    wr(0, 16'd2);
    edges(5);
    check("R5 unbounded", count, 5);

    // R9 and R10 queued period applied on natural zero
    wr(1, 16'd1);
    wr(0, 16'd2);
    wr(3, 16'd6);
    check("R10 after shadow write", count, 1);
    edges(3);
    check("R9 zero count", count, 0);
    check("R9 strobe", zeroStrobe, 1);
    edges(1);
    check("R9 strobe one cycle", zeroStrobe, 0);
    edges(5);
    check("R10 new period reached", count, 6);
    edges(1);
    check("R10 wrap at new period", count, 0);

    // R11 mode write drops queued period, restart applies nothing
    wr(2, 16'd3);
    wr(3, 16'd9);
    wr(0, 16'd2);
    edges(8);
    check("R11 queued period discarded", count, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule